// File: doc/BRIEF.md
# Masked partial-match content-addressable memory

This block keeps a table of detector words, each with its own valid flag. Every cycle it compares one search word against all stored entries at once. Each comparison can be limited to a window of adjacent bit positions, given by a start position and a length. Bits outside the window do not take part. The block drives one match bit per entry, plus a single flag that is high when any entry matches.

Detector words are loaded through a write port. The write port gives an entry index, a data word and a valid bit, and takes effect at the rising clock edge. The compare path is purely combinational from the stored state and the search inputs, so a search is answered in the same cycle it is presented. The width of the window can be changed from one search to the next. A window that spans the full word gives an exact whole-word compare. A window that runs past the top bit is cut off at the word width.

The asynchronous active-low reset clears every valid flag. It is released through a two-stage synchroniser, so the first write that can take effect is accepted at the third rising edge after reset is released.

Top module: `mcam_top`

## Requirements
- R1: While reset is held, and after reset until a write with the valid bit set, no bit of match_vec is high and found is low, for any search inputs.
- R2: When wr_en is high at a rising edge, wr_data and wr_valid are stored in entry wr_idx. A search in that same cycle still sees the previous contents of the entry, and searches from the next cycle see the new contents.
- R3: With srch_start = 0 and srch_len = 32, match_vec[k] is high exactly when entry k is valid and its stored word equals srch_key in all 32 bits.
- R4: Bit position i (0 = LSB) takes part in the compare exactly when srch_start <= i < srch_start + srch_len. A mismatch at any other position has no effect on the result.
- R5: When srch_start + srch_len is greater than 32, the window is clipped to bits srch_start..31, and no error or wrap-around occurs.
- R6: With srch_len = 0 the window is empty, and every valid entry reports a match.
- R7: An entry whose valid bit is 0 never sets its match bit, whatever its stored data and the search inputs. Writing an entry with wr_valid = 0 invalidates it.
- R8: match_vec bit k reports entry k. All entries are compared in parallel, and the result follows the search inputs in the same cycle, with no clock edge in between.
- R9: found is high exactly when at least one bit of match_vec is high.
- R10: When wr_en is low, the values on wr_idx, wr_data and wr_valid change no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for one entry |
| wr_idx | input | 7 | Entry index to write |
| wr_data | input | 32 | Detector word to store |
| wr_valid | input | 1 | Valid flag stored with the word (0 invalidates the entry) |
| srch_key | input | 32 | Search word |
| srch_start | input | 5 | Lowest bit position of the compare window |
| srch_len | input | 6 | Number of adjacent bits in the window, 0 to 32 |
| match_vec | output | 128 | One match bit per entry |
| found | output | 1 | High when any entry matches |

## Verification
The bench searches while it writes the same entry, to confirm that the old contents are still seen in that cycle. A design that bypassed the write data into the compare would report the new word one cycle early. The bench uses keys that are wrong only outside the window, and windows that run past bit 31. A mask built with a narrow sum or an off-by-one bound would either drop a matching entry or wrap the window onto the low bits. Empty windows, invalidated entries, and writes with the strobe low are checked against the per-entry reference. A design that ignored the valid flag, or that stored data without the strobe, would show stray match bits.

// File: rtl/mcam_pkg.sv
package mcam_pkg;

  localparam int unsigned MCAM_WORD_W = 32;
  localparam int unsigned MCAM_DEPTH  = 128;

  // Bits needed to hold a value in 0..n-1, never less than one.
  function automatic int unsigned idx_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Bits needed to hold a value in 0..n.
  function automatic int unsigned cnt_bits(input int unsigned n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/mcam_rst_sync.sv
module mcam_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/mcam_window_mask.sv
module mcam_window_mask #(
  parameter int unsigned WORD_W = mcam_pkg::MCAM_WORD_W,
  localparam int unsigned POS_W = mcam_pkg::idx_bits(WORD_W),
  localparam int unsigned LEN_W = mcam_pkg::cnt_bits(WORD_W)
) (
  input  logic [POS_W-1:0]  win_start,
  input  logic [LEN_W-1:0]  win_len,
  output logic [WORD_W-1:0] win_mask
);

  // The upper bound is formed one bit wider than either operand, so a
  // window that runs past the top bit simply clips instead of wrapping.
  localparam int unsigned END_W = ((POS_W > LEN_W) ? POS_W : LEN_W) + 1;

  logic [END_W-1:0] win_end;

  always_comb begin
    win_end = END_W'(win_start) + END_W'(win_len);
  end

  for (genvar b = 0; b < WORD_W; b++) begin : g_bit
    localparam logic [END_W-1:0] BPOS = END_W'(b);
    assign win_mask[b] = (END_W'(win_start) <= BPOS) && (BPOS < win_end);
  end

endmodule

// File: rtl/mcam_store.sv
module mcam_store #(
  parameter int unsigned WORD_W = mcam_pkg::MCAM_WORD_W,
  parameter int unsigned DEPTH  = mcam_pkg::MCAM_DEPTH,
  localparam int unsigned IDX_W = mcam_pkg::idx_bits(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              wr_valid,
  output logic [WORD_W-1:0] ent_data [DEPTH],
  output logic [DEPTH-1:0]  ent_valid
);

  logic [DEPTH-1:0] wr_sel;
  logic [DEPTH-1:0] valid_d;
  logic [DEPTH-1:0] valid_q;

  // One-hot entry select; an index beyond the depth selects nothing.
  always_comb begin
    wr_sel = '0;
    if (wr_en && (int'(wr_idx) < int'(DEPTH))) begin
      wr_sel[wr_idx] = 1'b1;
    end
  end

  always_comb begin
    valid_d = valid_q;
    for (int k = 0; k < int'(DEPTH); k++) begin
      if (wr_sel[k]) begin
        valid_d[k] = wr_valid;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      valid_q <= valid_d;
    end
  end

  // Data words carry no reset: their valid flag guards every use.
  for (genvar k = 0; k < DEPTH; k++) begin : g_ent
    logic [WORD_W-1:0] data_q;

    always_ff @(posedge clk) begin
      if (wr_sel[k]) begin
        data_q <= wr_data;
      end
    end

    assign ent_data[k] = data_q;
  end

  assign ent_valid = valid_q;

endmodule

// File: rtl/mcam_compare.sv
module mcam_compare #(
  parameter int unsigned WORD_W = mcam_pkg::MCAM_WORD_W,
  parameter int unsigned DEPTH  = mcam_pkg::MCAM_DEPTH
) (
  input  logic [WORD_W-1:0] ent_data [DEPTH],
  input  logic [DEPTH-1:0]  ent_valid,
  input  logic [WORD_W-1:0] key,
  input  logic [WORD_W-1:0] care_mask,
  output logic [DEPTH-1:0]  hit
);

  for (genvar k = 0; k < DEPTH; k++) begin : g_cmp
    logic [WORD_W-1:0] diff;
    assign diff   = (ent_data[k] ^ key) & care_mask;
    assign hit[k] = ent_valid[k] && (diff == '0);
  end

endmodule

// File: rtl/mcam_top.sv
module mcam_top #(
  parameter int unsigned WORD_W = mcam_pkg::MCAM_WORD_W,
  parameter int unsigned DEPTH  = mcam_pkg::MCAM_DEPTH,
  localparam int unsigned IDX_W = mcam_pkg::idx_bits(DEPTH),
  localparam int unsigned POS_W = mcam_pkg::idx_bits(WORD_W),
  localparam int unsigned LEN_W = mcam_pkg::cnt_bits(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              wr_valid,
  input  logic [WORD_W-1:0] srch_key,
  input  logic [POS_W-1:0]  srch_start,
  input  logic [LEN_W-1:0]  srch_len,
  output logic [DEPTH-1:0]  match_vec,
  output logic              found
);

  logic              rst_core_n;
  logic [WORD_W-1:0] care_mask;
  logic [WORD_W-1:0] ent_data [DEPTH];
  logic [DEPTH-1:0]  ent_valid;

  mcam_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_core_n)
  );

  mcam_window_mask #(.WORD_W(WORD_W)) u_mask (
    .win_start (srch_start),
    .win_len   (srch_len),
    .win_mask  (care_mask)
  );

  mcam_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .wr_valid  (wr_valid),
    .ent_data  (ent_data),
    .ent_valid (ent_valid)
  );

  mcam_compare #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_cmp (
    .ent_data  (ent_data),
    .ent_valid (ent_valid),
    .key       (srch_key),
    .care_mask (care_mask),
    .hit       (match_vec)
  );

  assign found = |match_vec;

endmodule

// File: rtl/mcam_chk.sv
module mcam_chk #(
  parameter int unsigned WORD_W = mcam_pkg::MCAM_WORD_W,
  parameter int unsigned DEPTH  = mcam_pkg::MCAM_DEPTH,
  localparam int unsigned IDX_W = mcam_pkg::idx_bits(DEPTH),
  localparam int unsigned POS_W = mcam_pkg::idx_bits(WORD_W),
  localparam int unsigned LEN_W = mcam_pkg::cnt_bits(WORD_W)
) (
  input logic              clk,
  input logic              rst_core_n,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [WORD_W-1:0] wr_data,
  input logic              wr_valid,
  input logic [WORD_W-1:0] srch_key,
  input logic [POS_W-1:0]  srch_start,
  input logic [LEN_W-1:0]  srch_len,
  input logic [DEPTH-1:0]  match_vec,
  input logic              found
);

  localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(WORD_W);

  logic seen_valid_q;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      seen_valid_q <= 1'b0;
    end else if (wr_en && wr_valid) begin
      seen_valid_q <= 1'b1;
    end
  end

  AST_NONE_BEFORE_WRITE: assert property (@(posedge clk) disable iff (!rst_core_n)
    !seen_valid_q |-> (match_vec == '0) && !found); // R1

  AST_WR_VISIBLE: assert property (@(posedge clk) disable iff (!rst_core_n)
    (wr_en && wr_valid) |=>
      (((srch_key == $past(wr_data)) && (srch_start == '0) && (srch_len == FULL_LEN))
        ? match_vec[$past(wr_idx)] : 1'b1)); // R2

  AST_WR_INVALID: assert property (@(posedge clk) disable iff (!rst_core_n)
    (wr_en && !wr_valid) |=> !match_vec[$past(wr_idx)]); // R7

  AST_EMPTY_STABLE: assert property (@(posedge clk) disable iff (!rst_core_n)
    ((srch_len == '0) && $past(srch_len == '0) && !$past(wr_en)) |-> $stable(match_vec)); // R6

endmodule

bind mcam_top mcam_chk #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/tb_mcam_top.sv
`timescale 1ns/1ps
module tb_mcam_top;

  localparam int W = 32;
  localparam int D = 128;
  localparam int CYC = 20;

  logic          clk;
  logic          rst_n;
  logic          wr_en;
  logic [6:0]    wr_idx;
  logic [W-1:0]  wr_data;
  logic          wr_valid;
  logic [W-1:0]  srch_key;
  logic [4:0]    srch_start;
  logic [5:0]    srch_len;
  logic [D-1:0]  match_vec;
  logic          found;

  int tests_run;
  int tests_failed;

  logic [W-1:0] ref_data  [D];
  bit           ref_valid [D];
  logic [31:0]  lf;

  mcam_top dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .wr_valid(wr_valid), .srch_key(srch_key),
    .srch_start(srch_start), .srch_len(srch_len),
    .match_vec(match_vec), .found(found)
  );

  initial clk = 1'b0;
  always #(CYC/2) clk = ~clk;

  function automatic logic [W-1:0] pat(input int k);
    return (32'(k) * 32'h9E37_79B9) + 32'h0123_4567;
  endfunction

  function automatic logic ref_hit(input int k, input logic [W-1:0] key,
                                   input int st, input int ln);
    if (!ref_valid[k]) return 1'b0;
    for (int i = 0; i < W; i++) begin
      if (i >= st && i < st + ln && ref_data[k][i] != key[i]) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
  endtask

  // One cycle: drive at the falling edge, compare before the rising edge,
  // then commit the write into the reference model.
  task automatic cyc(input logic we, input int idx, input logic [W-1:0] d,
                     input logic v, input logic [W-1:0] key, input int st,
                     input int ln, input string tag);
    logic [D-1:0] exp_vec;
    logic         exp_found;
    @(negedge clk);
    wr_en = we; wr_idx = 7'(idx); wr_data = d; wr_valid = v;
    srch_key = key; srch_start = 5'(st); srch_len = 6'(ln);
    #(CYC/4);
    for (int k = 0; k < D; k++) exp_vec[k] = ref_hit(k, key, st, ln);
    exp_found = |exp_vec;
    tests_run++;
    if (match_vec !== exp_vec) begin
      tests_failed++;
      $display("FAIL %s match_vec actual=%h expected=%h (key=%h start=%0d len=%0d)",
               tag, match_vec, exp_vec, key, st, ln);
    end
    tests_run++;
    if (found !== exp_found) begin
      tests_failed++;
      $display("FAIL R9 found actual=%b expected=%b", found, exp_found);
    end
    if (we && rst_n) begin
      ref_data[idx]  = d;
      ref_valid[idx] = v;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests_run++;
    tests_failed++;
    $display("FAIL watchdog expired actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    tests_run = 0; tests_failed = 0;
    for (int k = 0; k < D; k++) begin ref_data[k] = '0; ref_valid[k] = 1'b0; end
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_data = '0; wr_valid = 1'b0;
    srch_key = '0; srch_start = '0; srch_len = '0;
    repeat (3) @(posedge clk);
    // R1: nothing matches while reset is held, even with an empty window.
    cyc(1'b0, 0, '0, 1'b0, '0, 0, 0, "R1");
    @(negedge clk); rst_n = 1'b1;
    // R1: synchroniser still holding the core in reset, and then idle.
    cyc(1'b0, 0, '0, 1'b0, '0, 0, 0, "R1");
    cyc(1'b0, 0, '0, 1'b0, pat(0), 0, 32, "R1");
    cyc(1'b0, 0, '0, 1'b0, '0, 0, 0, "R1");

    // R2: load every entry; search the word being written in the same cycle.
    for (int k = 0; k < D; k++) cyc(1'b1, k, pat(k), 1'b1, pat(k), 0, 32, "R2");
    // R2: the last word written is visible in the next cycle.
    cyc(1'b0, 0, '0, 1'b0, pat(D-1), 0, 32, "R2");

    // R3 / R8: exact full-width searches across the table.
    for (int k = 0; k < D; k += 8) cyc(1'b0, 0, '0, 1'b0, pat(k), 0, 32, "R3");
    cyc(1'b0, 0, '0, 1'b0, pat(5) ^ 32'h0000_0001, 0, 32, "R3");

    // R4: mismatches only outside the window are ignored.
    cyc(1'b0, 0, '0, 1'b0, pat(5) ^ 32'hFFFF_0000, 0, 16, "R4");
    cyc(1'b0, 0, '0, 1'b0, pat(5) ^ 32'h0000_FFFF, 16, 16, "R4");
    cyc(1'b0, 0, '0, 1'b0, pat(5) ^ 32'h0000_FFFF, 15, 16, "R4");
    cyc(1'b0, 0, '0, 1'b0, pat(40) ^ 32'hF000_000F, 4, 24, "R4");

    // R5: windows that run past bit 31.
    cyc(1'b0, 0, '0, 1'b0, pat(9) ^ 32'h0FFF_FFFF, 28, 10, "R5");
    cyc(1'b0, 0, '0, 1'b0, pat(9) ^ 32'h7FFF_FFFF, 31, 32, "R5");
    cyc(1'b0, 0, '0, 1'b0, pat(9) ^ 32'h8000_0000, 31, 32, "R5");

    // R6: empty window matches every valid entry.
    cyc(1'b0, 0, '0, 1'b0, 32'hDEAD_BEEF, 0, 0, "R6");
    cyc(1'b0, 0, '0, 1'b0, 32'h1234_0000, 20, 0, "R6");

    // R7: invalidate two entries and search for their old words.
    cyc(1'b1, 3, pat(3), 1'b0, '0, 0, 0, "R7");
    cyc(1'b1, 7, pat(7), 1'b0, pat(3), 0, 32, "R7");
    cyc(1'b0, 0, '0, 1'b0, pat(7), 0, 32, "R7");
    cyc(1'b0, 0, '0, 1'b0, '0, 0, 0, "R7");

    // R10: strobe low leaves entry 10 untouched.
    cyc(1'b0, 10, 32'h0, 1'b0, pat(10), 0, 32, "R10");
    cyc(1'b0, 10, 32'hFFFF_FFFF, 1'b1, pat(10), 0, 32, "R10");
    cyc(1'b0, 0, '0, 1'b0, 32'hFFFF_FFFF, 0, 32, "R10");

    // R2: revive entry 3 with a new word.
    cyc(1'b1, 3, 32'hA5A5_5A5A, 1'b1, 32'hA5A5_5A5A, 0, 32, "R2");
    cyc(1'b0, 0, '0, 1'b0, 32'hA5A5_5A5A, 0, 32, "R2");

    // R4 / R8: mixed traffic from a pseudo-random source.
    lf = 32'hC0FF_EE11;
    for (int n = 0; n < 800; n++) begin
      int   idx;
      int   st;
      int   ln;
      logic we;
      logic [W-1:0] key;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      idx = int'(lf[6:0]);
      st  = int'(lf[11:7]);
      ln  = int'(lf[17:12]) % 33;
      we  = (lf[19:18] == 2'b00);
      key = pat(int'(lf[26:20])) ^ (lf[27] ? (32'h1 << lf[31:28]) : 32'h0);
      cyc(we, idx, pat(idx) ^ {lf[15:0], 16'h0}, lf[29] | lf[30], key, st, ln, "R8");
    end

    summary();
    $finish;
  end

endmodule